// File: doc/BRIEF.md
# Segmented Vector Load Address Sequencer

This block turns one predicated vector load into a stream of single memory accesses. It is given a base address, an element size, a scalar stride, a segment length, a vector length, a predicate mask and a set of per-element index values. One accepted request on each handshake then carries an address, the destination register number and the element position that the returned data belongs to.

Three addressing modes are supported. In unit-stride mode the step between accesses equals the element size. In constant-stride mode the step comes from a scalar register. In indexed mode the offset-source register is vectorised, and each element's offset is taken from that register's element. Every enabled element is a segment of `segLen+1` consecutive fields. Field j of element i goes to destination register `destReg+j`. Elements that the predicate disables produce no access at all.

Operands are captured on `start` while the block is idle. Requests then wait on `reqReady`, and a single-cycle `done` follows the final accepted access.

Top module: `seg_load_agen`

## Requirements
- R1: After reset `reqValid`, `done` and `busy` are all 0.
- R2: With `unitStride`=1 and `idxVectorised`=0, field j of element i is fetched from `baseAddr + i*(segLen+1)*elemSize + j*elemSize`.
- R3: With `unitStride`=0 and `idxVectorised`=0, field j of element i is fetched from `baseAddr + i*(segLen+1)*strideReg + j*strideReg`.
- R4: With `idxVectorised`=1, field j of element i is fetched from `baseAddr + idxVals[i*ADDR_W +: ADDR_W] + j*S`, where S is `elemSize` when `unitStride`=1 and `strideReg` otherwise.
- R5: Requests are issued with the field index j as the inner loop (0..segLen) and the element index i as the outer loop in ascending order. `reqElem` equals i, and `reqReg` equals `destReg + j` modulo 2^REG_W.
- R6: With `predEnable`=1, element i is processed only when `predMask[i] XOR predInvert` is 1. A disabled element produces no request.
- R7: With `predEnable`=0, every element 0..vecLen-1 is processed, whatever `predMask` and `predInvert` hold.
- R8: No element with index at or above `vecLen` is ever requested. A run with no enabled element issues no request and still ends with `done`.
- R9: While `reqValid`=1 and `reqReady`=0, the next cycle keeps `reqValid` high and `reqAddr`, `reqReg`, `reqElem` unchanged.
- R10: `done` is high for exactly one cycle. That cycle is the one after the last accepted request, or the cycle after `start` when nothing is enabled. `busy` is 1 from the cycle after `start` through the `done` cycle and 0 afterwards.
- R11: A `start` pulse while `busy`=1 is ignored, and the running sequence keeps its captured operands.
- R12: All address arithmetic wraps modulo 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Capture operands and begin a run (used only when idle) |
| baseAddr | input | ADDR_W | Scalar base address |
| elemSize | input | ADDR_W | Element size in bytes, the step in unit-stride mode |
| strideReg | input | ADDR_W | Scalar stride value |
| unitStride | input | 1 | 1 selects the element size as the step |
| idxVectorised | input | 1 | 1 selects indexed mode (offset register is vectorised) |
| idxVals | input | VL_MAX*ADDR_W | Per-element offsets, element i in bits [i*ADDR_W +: ADDR_W] |
| segLen | input | SEG_W | Fields per element minus one |
| vecLen | input | CNT_W | Vector length, 0..VL_MAX |
| destReg | input | REG_W | First destination register |
| predEnable | input | 1 | A predicate is configured for the destination |
| predInvert | input | 1 | Invert the predicate bits |
| predMask | input | VL_MAX | Predicate bits, bit i for element i |
| reqReady | input | 1 | Memory side accepts the current request |
| reqValid | output | 1 | A request is presented |
| reqAddr | output | ADDR_W | Access address |
| reqReg | output | REG_W | Destination register for this field |
| reqElem | output | IDX_W | Element position inside the register |
| done | output | 1 | One-cycle end-of-run pulse |
| busy | output | 1 | A run is in progress |

## Verification
The main function is driven under unit-stride, constant-stride and indexed operands, with segments of one, two and three fields. The memory side is either always ready, ready every other cycle, or stalled on every third cycle, so the address and field sequencing is checked apart from the handshake timing. Predicate patterns include a sparse mask, the same mask inverted, a mask ignored because no predicate is configured, and masks whose only set bits lie at or above the vector length. Together they show whether skipping comes from the predicate, from the vector length, or from neither. A base near the top of the address space and a destination register of 31 show that both addresses and register numbers wrap, and a second start issued mid-run shows that captured operands are not disturbed.

// File: rtl/seg_agen_pkg.sv
`timescale 1ns/1ps
package seg_agen_pkg;

  // Strobes sent from the sequencing control to the address datapath.
  typedef struct packed {
    logic load;       // capture operands, clear field counter
    logic fieldStep;  // accepted access, more fields remain in this element
    logic fieldClr;   // accepted access was the last field of the element
  } agenStrobe_t;

endpackage

// File: rtl/seg_agen_ctrl.sv
`timescale 1ns/1ps
module seg_agen_ctrl
  import seg_agen_pkg::*;
#(
  parameter int VL_MAX = 8,
  localparam int IDX_W = $clog2(VL_MAX),
  localparam int CNT_W = $clog2(VL_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] vecLen,
  input  logic             predEnable,
  input  logic             predInvert,
  input  logic [VL_MAX-1:0] predMask,
  input  logic             reqReady,
  input  logic             lastField,
  output agenStrobe_t      strobe,
  output logic             reqValid,
  output logic [IDX_W-1:0] elemIdx,
  output logic             done,
  output logic             busy
);

  logic              running;
  logic [VL_MAX-1:0] pending;
  logic [VL_MAX-1:0] startMask;
  logic              anyPending;
  logic              fire;

  // Elements enabled at capture time: inside the vector length and
  // passing the (optionally inverted) predicate, or all when none is set.
  for (genvar g = 0; g < VL_MAX; g++) begin : g_enable
    logic inLen;
    logic predOk;
    assign inLen        = (CNT_W'(g) < vecLen);
    assign predOk       = predEnable ? (predMask[g] ^ predInvert) : 1'b1;
    assign startMask[g] = inLen & predOk;
  end

  // Lowest pending element is the one served next.
  always_comb begin
    elemIdx = '0;
    for (int k = VL_MAX - 1; k >= 0; k--) begin
      if (pending[k]) elemIdx = IDX_W'(k);
    end
  end

  assign anyPending = |pending;
  assign reqValid   = running & anyPending;
  assign fire       = reqValid & reqReady;
  assign done       = running & ~anyPending;
  assign busy       = running;

  always_comb begin
    strobe           = '0;
    strobe.load      = start & ~running;
    strobe.fieldStep = fire & ~lastField;
    strobe.fieldClr  = fire & lastField;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      pending <= '0;
    end else if (strobe.load) begin
      running <= 1'b1;
      pending <= startMask;
    end else if (running) begin
      if (!anyPending) begin
        running <= 1'b0;
      end else if (strobe.fieldClr) begin
        pending <= pending & ~(VL_MAX'(1) << elemIdx);
      end
    end
  end

endmodule

// File: rtl/seg_agen_dp.sv
`timescale 1ns/1ps
module seg_agen_dp
  import seg_agen_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int VL_MAX = 8,
  parameter int REG_W  = 5,
  parameter int SEG_W  = 3,
  localparam int IDX_W = $clog2(VL_MAX)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  agenStrobe_t              strobe,
  input  logic [ADDR_W-1:0]        baseAddr,
  input  logic [ADDR_W-1:0]        elemSize,
  input  logic [ADDR_W-1:0]        strideReg,
  input  logic                     unitStride,
  input  logic                     idxVectorised,
  input  logic [VL_MAX*ADDR_W-1:0] idxVals,
  input  logic [SEG_W-1:0]         segLen,
  input  logic [REG_W-1:0]         destReg,
  input  logic [IDX_W-1:0]         elemIdx,
  output logic [ADDR_W-1:0]        reqAddr,
  output logic [REG_W-1:0]         reqReg,
  output logic                     lastField
);

  logic [ADDR_W-1:0] baseQ;
  logic [ADDR_W-1:0] stepQ;       // step between fields
  logic [ADDR_W-1:0] elemStepQ;   // step between elements, (segLen+1)*step
  logic              indexedQ;
  logic [SEG_W-1:0]  segQ;
  logic [REG_W-1:0]  destQ;
  logic [SEG_W-1:0]  fieldQ;
  logic [ADDR_W-1:0] idxQ [VL_MAX];

  logic [ADDR_W-1:0] stepSel;
  logic [ADDR_W-1:0] elemOffset;
  logic [ADDR_W-1:0] fieldOffset;

  assign stepSel = unitStride ? elemSize : strideReg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      baseQ     <= '0;
      stepQ     <= '0;
      elemStepQ <= '0;
      indexedQ  <= 1'b0;
      segQ      <= '0;
      destQ     <= '0;
    end else if (strobe.load) begin
      baseQ     <= baseAddr;
      stepQ     <= stepSel;
      elemStepQ <= stepSel * (ADDR_W'(segLen) + ADDR_W'(1));
      indexedQ  <= idxVectorised;
      segQ      <= segLen;
      destQ     <= destReg;
    end
  end

  // Per-element offsets, captured once per run.
  for (genvar g = 0; g < VL_MAX; g++) begin : g_idx
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           idxQ[g] <= '0;
      else if (strobe.load) idxQ[g] <= idxVals[g*ADDR_W +: ADDR_W];
    end
  end

  // Field counter: inner loop of the walk.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                fieldQ <= '0;
    else if (strobe.load || strobe.fieldClr)   fieldQ <= '0;
    else if (strobe.fieldStep)                 fieldQ <= fieldQ + SEG_W'(1);
  end

  assign lastField   = (fieldQ == segQ);
  assign elemOffset  = indexedQ ? idxQ[elemIdx] : ADDR_W'(elemIdx) * elemStepQ;
  assign fieldOffset = ADDR_W'(fieldQ) * stepQ;
  assign reqAddr     = baseQ + elemOffset + fieldOffset;
  assign reqReg      = destQ + REG_W'(fieldQ);

endmodule

// File: rtl/seg_load_agen.sv
`timescale 1ns/1ps
module seg_load_agen
  import seg_agen_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int VL_MAX = 8,
  parameter int REG_W  = 5,
  parameter int SEG_W  = 3,
  localparam int IDX_W = $clog2(VL_MAX),
  localparam int CNT_W = $clog2(VL_MAX + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [ADDR_W-1:0]        baseAddr,
  input  logic [ADDR_W-1:0]        elemSize,
  input  logic [ADDR_W-1:0]        strideReg,
  input  logic                     unitStride,
  input  logic                     idxVectorised,
  input  logic [VL_MAX*ADDR_W-1:0] idxVals,
  input  logic [SEG_W-1:0]         segLen,
  input  logic [CNT_W-1:0]         vecLen,
  input  logic [REG_W-1:0]         destReg,
  input  logic                     predEnable,
  input  logic                     predInvert,
  input  logic [VL_MAX-1:0]        predMask,
  input  logic                     reqReady,
  output logic                     reqValid,
  output logic [ADDR_W-1:0]        reqAddr,
  output logic [REG_W-1:0]         reqReg,
  output logic [IDX_W-1:0]         reqElem,
  output logic                     done,
  output logic                     busy
);

  agenStrobe_t      strobe;
  logic             lastField;
  logic [IDX_W-1:0] elemIdx;

  seg_agen_ctrl #(.VL_MAX(VL_MAX)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .vecLen     (vecLen),
    .predEnable (predEnable),
    .predInvert (predInvert),
    .predMask   (predMask),
    .reqReady   (reqReady),
    .lastField  (lastField),
    .strobe     (strobe),
    .reqValid   (reqValid),
    .elemIdx    (elemIdx),
    .done       (done),
    .busy       (busy)
  );

  seg_agen_dp #(
    .ADDR_W (ADDR_W),
    .VL_MAX (VL_MAX),
    .REG_W  (REG_W),
    .SEG_W  (SEG_W)
  ) u_dp (
    .clk           (clk),
    .rst_n         (rst_n),
    .strobe        (strobe),
    .baseAddr      (baseAddr),
    .elemSize      (elemSize),
    .strideReg     (strideReg),
    .unitStride    (unitStride),
    .idxVectorised (idxVectorised),
    .idxVals       (idxVals),
    .segLen        (segLen),
    .destReg       (destReg),
    .elemIdx       (elemIdx),
    .reqAddr       (reqAddr),
    .reqReg        (reqReg),
    .lastField     (lastField)
  );

  assign reqElem = elemIdx;

endmodule

// File: rtl/seg_agen_chk.sv
`timescale 1ns/1ps
module seg_agen_chk #(
  parameter int ADDR_W = 32,
  parameter int VL_MAX = 8,
  parameter int REG_W  = 5,
  localparam int IDX_W = $clog2(VL_MAX),
  localparam int CNT_W = $clog2(VL_MAX + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic [CNT_W-1:0]  vecLen,
  input logic              predEnable,
  input logic              predInvert,
  input logic [VL_MAX-1:0] predMask,
  input logic              reqValid,
  input logic              reqReady,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [REG_W-1:0]  reqReg,
  input logic [IDX_W-1:0]  reqElem,
  input logic              done
);

  logic [CNT_W-1:0]  vlSeen;
  logic              peSeen;
  logic              piSeen;
  logic [VL_MAX-1:0] pmSeen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vlSeen <= '0;
      peSeen <= 1'b0;
      piSeen <= 1'b0;
      pmSeen <= '0;
    end else if (start && !busy) begin
      vlSeen <= vecLen;
      peSeen <= predEnable;
      piSeen <= predInvert;
      pmSeen <= predMask;
    end
  end

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid && !reqReady |=> reqValid && $stable(reqAddr) && $stable(reqReg) && $stable(reqElem));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !reqValid && busy);

  // R8
  elem_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |-> (CNT_W'(reqElem) < vlSeen));

  // R6
  pred_respected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid && peSeen |-> (pmSeen[reqElem] ^ piSeen));

  // R5
  elem_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid && reqReady |=> !reqValid || (reqElem >= $past(reqElem)));

  // R10
  valid_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |-> busy);

endmodule

bind seg_load_agen seg_agen_chk #(
  .ADDR_W (ADDR_W),
  .VL_MAX (VL_MAX),
  .REG_W  (REG_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .busy       (busy),
  .vecLen     (vecLen),
  .predEnable (predEnable),
  .predInvert (predInvert),
  .predMask   (predMask),
  .reqValid   (reqValid),
  .reqReady   (reqReady),
  .reqAddr    (reqAddr),
  .reqReg     (reqReg),
  .reqElem    (reqElem),
  .done       (done)
);

// File: tb/seg_load_agen_bench.sv
`timescale 1ns/1ps
module seg_load_agen_bench;

  localparam int ADDR_W = 32;
  localparam int VL_MAX = 8;
  localparam int REG_W  = 5;
  localparam int SEG_W  = 3;
  localparam int IDX_W  = $clog2(VL_MAX);
  localparam int CNT_W  = $clog2(VL_MAX + 1);
  localparam int EXP_N  = VL_MAX * (1 << SEG_W);

  logic                     clk = 1'b0;
  logic                     rst_n = 1'b0;
  logic                     start = 1'b0;
  logic [ADDR_W-1:0]        baseAddr = '0;
  logic [ADDR_W-1:0]        elemSize = '0;
  logic [ADDR_W-1:0]        strideReg = '0;
  logic                     unitStride = 1'b0;
  logic                     idxVectorised = 1'b0;
  logic [VL_MAX*ADDR_W-1:0] idxVals = '0;
  logic [SEG_W-1:0]         segLen = '0;
  logic [CNT_W-1:0]         vecLen = '0;
  logic [REG_W-1:0]         destReg = '0;
  logic                     predEnable = 1'b0;
  logic                     predInvert = 1'b0;
  logic [VL_MAX-1:0]        predMask = '0;
  logic                     reqReady = 1'b0;
  logic                     reqValid;
  logic [ADDR_W-1:0]        reqAddr;
  logic [REG_W-1:0]         reqReg;
  logic [IDX_W-1:0]         reqElem;
  logic                     done;
  logic                     busy;

  int checks = 0;
  int fails  = 0;

  logic [ADDR_W-1:0] expAddr [EXP_N];
  logic [REG_W-1:0]  expReg  [EXP_N];
  int                expElem [EXP_N];
  int                expCount;

  always #2.5 clk = ~clk;

  seg_load_agen #(
    .ADDR_W (ADDR_W), .VL_MAX (VL_MAX), .REG_W (REG_W), .SEG_W (SEG_W)
  ) u_seg_load_agen (
    .clk (clk), .rst_n (rst_n), .start (start),
    .baseAddr (baseAddr), .elemSize (elemSize), .strideReg (strideReg),
    .unitStride (unitStride), .idxVectorised (idxVectorised), .idxVals (idxVals),
    .segLen (segLen), .vecLen (vecLen), .destReg (destReg),
    .predEnable (predEnable), .predInvert (predInvert), .predMask (predMask),
    .reqReady (reqReady), .reqValid (reqValid), .reqAddr (reqAddr),
    .reqReg (reqReg), .reqElem (reqElem), .done (done), .busy (busy)
  );

  task automatic check(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  // Expected access list from the current operands, straight from the requirements.
  task automatic buildExpected();
    logic [ADDR_W-1:0] step;
    logic [ADDR_W-1:0] off;
    expCount = 0;
    step = unitStride ? elemSize : strideReg;
    for (int i = 0; i < int'(vecLen); i++) begin
      bit en;
      en = predEnable ? (predMask[i] ^ predInvert) : 1'b1;
      if (en) begin
        for (int j = 0; j <= int'(segLen); j++) begin
          if (idxVectorised) off = idxVals[i*ADDR_W +: ADDR_W];
          else               off = ADDR_W'(i) * (ADDR_W'(segLen) + 1) * step;
          expAddr[expCount] = baseAddr + off + ADDR_W'(j) * step;
          expReg[expCount]  = destReg + REG_W'(j);
          expElem[expCount] = i;
          expCount++;
        end
      end
    end
  endtask

  function automatic bit readyFor(input int mode, input int cyc);
    case (mode)
      1:       return (cyc % 2) == 1;
      2:       return (cyc % 3) != 0;
      default: return 1'b1;
    endcase
  endfunction

  // Runs one sequence and compares every accepted access and the end timing.
  task automatic runAndCheck(input string tag, input int mode, input bit pokeStart);
    int got = 0;
    int cyc = 0;
    int lastFire = -1;
    bit seenDone = 0;
    bit prevStall = 0;
    logic [ADDR_W-1:0] pAddr = '0;
    logic [REG_W-1:0]  pReg = '0;
    logic [IDX_W-1:0]  pElem = '0;
    buildExpected();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (!seenDone && cyc < 400) begin
      reqReady = readyFor(mode, cyc);
      if (pokeStart && cyc == 2) begin
        start = 1'b1;
        baseAddr = baseAddr + 32'h0001_0000;
        vecLen = '0;
      end
      if (pokeStart && cyc == 3) start = 1'b0;
      #1;
      if (cyc == 0) check(tag, "busy after start (R10)", busy, 1);
      if (prevStall) begin
        check("R9", "valid held", reqValid, 1);
        check("R9", "addr held", reqAddr, pAddr);
        check("R9", "reg/elem held", {reqReg, reqElem}, {pReg, pElem});
      end
      if (reqValid && reqReady) begin
        if (got < expCount) begin
          check(tag, "address", reqAddr, expAddr[got]);
          check(tag, "dest reg (R5)", reqReg, expReg[got]);
          check(tag, "element (R5)", reqElem, expElem[got]);
        end else begin
          check(tag, "extra access (R8)", got, expCount - 1);
        end
        got++;
        lastFire = cyc;
      end
      if (done) begin
        seenDone = 1;
        check(tag, "access count", got, expCount);
        check("R10", "done timing", cyc, (expCount == 0) ? 0 : lastFire + 1);
        check("R10", "no valid with done", reqValid, 0);
      end
      prevStall = reqValid && !reqReady;
      pAddr = reqAddr; pReg = reqReg; pElem = reqElem;
      cyc++;
      @(negedge clk);
    end
    if (!seenDone) check(tag, "watchdog: no done", 0, 1);
    #1;
    check("R10", "done single cycle", done, 0);
    check("R10", "idle after done", busy, 0);
    reqReady = 1'b0;
  endtask

  task automatic setIdx();
    for (int i = 0; i < VL_MAX; i++)
      idxVals[i*ADDR_W +: ADDR_W] = 32'h40 * ADDR_W'(i * i) + 32'h4;
  endtask

  task automatic testReset();
    #1;
    check("R1", "reqValid", reqValid, 0);
    check("R1", "done", done, 0);
    check("R1", "busy", busy, 0);
  endtask

  task automatic testUnitStride();
    baseAddr = 32'h1000; elemSize = 32'h4; strideReg = 32'hDEAD; unitStride = 1;
    idxVectorised = 0; segLen = 3'd2; vecLen = 4'd4; destReg = 5'd8;
    predEnable = 0; predMask = '0;
    runAndCheck("R2", 0, 0);
  endtask

  task automatic testConstStride();
    baseAddr = 32'h2000; elemSize = 32'h8; strideReg = 32'h100; unitStride = 0;
    idxVectorised = 0; segLen = 3'd0; vecLen = 4'd8; destReg = 5'd1;
    predEnable = 0;
    runAndCheck("R3", 1, 0);
  endtask

  task automatic testIndexed();
    setIdx();
    baseAddr = 32'h8000; elemSize = 32'h2; strideReg = 32'h10; unitStride = 0;
    idxVectorised = 1; segLen = 3'd1; vecLen = 4'd5; destReg = 5'd4;
    predEnable = 0;
    runAndCheck("R4", 2, 0);
    unitStride = 1;
    runAndCheck("R4", 0, 0);
  endtask

  task automatic testPredicate();
    baseAddr = 32'h300; elemSize = 32'h4; unitStride = 1; idxVectorised = 0;
    segLen = 3'd1; vecLen = 4'd8; destReg = 5'd10;
    predEnable = 1; predInvert = 0; predMask = 8'b1010_0110;
    runAndCheck("R6", 2, 0);
    predInvert = 1;
    runAndCheck("R6", 1, 0);
  endtask

  task automatic testNoPredicate();
    baseAddr = 32'h500; elemSize = 32'h4; unitStride = 1; idxVectorised = 0;
    segLen = 3'd2; vecLen = 4'd3; destReg = 5'd2;
    predEnable = 0; predInvert = 1; predMask = 8'h00;
    runAndCheck("R7", 0, 0);
  endtask

  task automatic testLength();
    baseAddr = 32'h600; elemSize = 32'h4; unitStride = 1; idxVectorised = 0;
    segLen = 3'd0; predEnable = 0; vecLen = 4'd0;
    runAndCheck("R8", 0, 0);
    predEnable = 1; predInvert = 0; predMask = 8'b1111_1000; vecLen = 4'd3;
    runAndCheck("R8", 0, 0);
    predMask = 8'hFF; vecLen = 4'd2; segLen = 3'd3;
    runAndCheck("R8", 1, 0);
  endtask

  task automatic testBusyStart();
    baseAddr = 32'h7000; strideReg = 32'h20; unitStride = 0; idxVectorised = 0;
    segLen = 3'd1; vecLen = 4'd4; destReg = 5'd6; predEnable = 0;
    runAndCheck("R11", 1, 1);
  endtask

  task automatic testWrap();
    baseAddr = 32'hFFFF_FFF0; strideReg = 32'h8; unitStride = 0; idxVectorised = 0;
    segLen = 3'd1; vecLen = 4'd3; destReg = 5'd31; predEnable = 0;
    runAndCheck("R12", 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish (actual hung, expected finish)");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    testUnitStride();
    testConstStride();
    testIndexed();
    testPredicate();
    testNoPredicate();
    testLength();
    testBusyStart();
    testWrap();
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule